// File: doc/BRIEF.md
# Oversampled Serial Receiver with Error-Tagged Buffer

This block receives asynchronous serial characters on a single line. It takes samples at sixteen times the bit rate and confirms each start bit at mid-bit. It then collects five to nine data bits, least significant first, plus an optional parity bit and a stop bit. The frame settings and the rate divisor are the same ones the companion transmitter uses.

Each finished character is written into a two-entry buffer, and its parity and framing error flags are stored with it. A consumer therefore always sees a character's errors in the same word as its data. The buffer output is a valid/ready stream. A word is removed on a clock edge where `rx_valid_o` and `rx_ready_i` are both high. While ready is low the head word stays where it is, and the receiver keeps filling the second entry. A character that arrives when both entries are occupied is dropped, and a one-cycle overflow pulse is raised. Separate enable and disable strobes start and stop reception.

Top module: `serial_rx_tagged`

## Requirements
- R1: The output word holds the data in bits 8:0, received least significant bit first, and unused high data bits are zero. Bit 14 is the parity-error flag and bit 15 is the framing-error flag. Bits 13:9 always read zero.
- R2: `char_len_i` selects the number of data bits, 5 to 9. `parity_sel_i` selects the parity: 2'b00 for none, 2'b10 for even, 2'b11 for odd, and 2'b01 behaves as none. `two_stop_i` selects two stop bits.
- R3: A low level on the line starts a frame only if it is still low at the eighth oversample. A shorter low pulse is ignored and produces no word.
- R4: When parity is on, a received parity bit that does not match the configured sense sets bit 14 of that character's word.
- R5: A low first stop bit sets bit 15. When `two_stop_i` is set, the level of the second stop bit is never checked and never raises an error.
- R6: A break (line held low) produces exactly one word, with bit 15 set and all data bits zero. No further frame starts until the line has returned high.
- R7: The buffer holds two words in arrival order. `rx_valid_o` is high while at least one word is held. The head word stays stable until it is popped by valid and ready.
- R8: A character that completes while both entries are held, with no pop in that cycle, is discarded. The held words are kept, and `overflow_o` pulses high for one cycle.
- R9: After reset the receiver is disabled, and `rx_en_i` enables it. `rx_dis_i` discards any partial frame, and the line is then ignored until the next enable. If both strobes are high in the same cycle, disable wins.
- R10: One oversample lasts `div_i`+1 clock cycles, so one bit lasts 16×(`div_i`+1) cycles.
- R11: Out of reset, `rx_valid_o` and `overflow_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_i | input | 1 | Serial line, idle high |
| rx_en_i | input | 1 | Enable strobe |
| rx_dis_i | input | 1 | Disable strobe, flushes a partial frame |
| char_len_i | input | 4 | Data bits per character, 5..9 |
| parity_sel_i | input | 2 | Parity mode: 00 none, 10 even, 11 odd |
| two_stop_i | input | 1 | Two stop bits per frame |
| div_i | input | DIV_W | Oversample divisor minus one |
| rx_word_o | output | 16 | Head word: {ferr, perr, 5'b0, data[8:0]} |
| rx_valid_o | output | 1 | Buffer holds at least one word |
| rx_ready_i | input | 1 | Consumer accepts the head word |
| overflow_o | output | 1 | One-cycle pulse when a character is dropped |

## Verification
The bench builds the block with its default parameters: a two-entry buffer, sixteen oversamples per bit and a 16-bit divisor field. It drives divisor values 3 and 1, which give 64-clock and 32-clock bits, so many complete frames fit into a short run and the effect of the divisor can be seen. With only two entries, the third unread frame reaches the overflow path, and stability of the head word under back-pressure is checked in the same scenario. The short bit times also make breaks, start glitches and mid-frame disables cheap to produce.

// File: rtl/srx_pkg.sv
package srx_pkg;

  localparam int DATA_MAX  = 9;
  localparam int MIN_BITS  = 5;
  localparam int WORD_W    = 16;
  localparam int PERR_POS  = 14;
  localparam int FERR_POS  = 15;

  typedef enum logic [1:0] {
    PAR_NONE = 2'b00,
    PAR_RSVD = 2'b01,
    PAR_EVEN = 2'b10,
    PAR_ODD  = 2'b11
  } par_sel_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP,
    ST_STOP2,
    ST_HOLD
  } rx_state_e;

  typedef struct packed {
    logic                ferr;
    logic                perr;
    logic [DATA_MAX-1:0] data;
  } rx_entry_t;

  function automatic logic [WORD_W-1:0] pack_word(input rx_entry_t e);
    logic [WORD_W-1:0] w;
    w = '0;
    w[DATA_MAX-1:0] = e.data;
    w[PERR_POS]     = e.perr;
    w[FERR_POS]     = e.ferr;
    return w;
  endfunction

endpackage

// File: rtl/srx_tick.sv
module srx_tick #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);

  logic [DIV_W-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!run_i) begin
      cnt_q <= '0;
    end else if (cnt_q == '0) begin
      cnt_q <= div_i;
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  // R10: with a non-zero divisor, oversample ticks never come back to back
  a_r10_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_o && div_i != '0) |=> !tick_o);

endmodule

// File: rtl/srx_frame.sv
module srx_frame
  import srx_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tick_i,
  input  logic      rx_i,
  input  logic      enabled_i,
  input  logic      flush_i,
  input  logic [3:0] char_len_i,
  input  logic [1:0] parity_sel_i,
  input  logic      two_stop_i,
  output logic      push_o,
  output rx_entry_t entry_o
);

  localparam int CNT_W = $clog2(OSR);
  localparam int HALF  = OSR / 2;
  localparam int LEN_W = 4;

  rx_state_e           st_q;
  logic [CNT_W-1:0]    cnt_q;
  logic [LEN_W-1:0]    bitn_q;
  logic [DATA_MAX-1:0] sh_q;
  logic                par_acc_q;
  logic                perr_q;
  logic [LEN_W-1:0]    len_eff;
  logic [DATA_MAX-1:0] aligned;
  logic                at_mid;
  logic                par_on;
  logic                par_odd;

  always_comb begin
    if (char_len_i < LEN_W'(MIN_BITS))      len_eff = LEN_W'(MIN_BITS);
    else if (char_len_i > LEN_W'(DATA_MAX)) len_eff = LEN_W'(DATA_MAX);
    else                                    len_eff = char_len_i;
  end

  assign aligned = sh_q >> (LEN_W'(DATA_MAX) - len_eff);
  assign at_mid  = (cnt_q == CNT_W'(OSR - 1));
  assign par_on  = parity_sel_i[1];
  assign par_odd = (parity_sel_i == PAR_ODD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      cnt_q     <= '0;
      bitn_q    <= '0;
      sh_q      <= '0;
      par_acc_q <= 1'b0;
      perr_q    <= 1'b0;
      push_o    <= 1'b0;
      entry_o   <= '0;
    end else begin
      push_o <= 1'b0;
      if (flush_i) begin
        st_q   <= ST_IDLE;
        cnt_q  <= '0;
        bitn_q <= '0;
      end else if (enabled_i && tick_i) begin
        unique case (st_q)
          ST_IDLE: begin
            if (!rx_i) begin
              st_q  <= ST_START;
              cnt_q <= CNT_W'(1);
            end
          end
          ST_START: begin
            if (cnt_q == CNT_W'(HALF - 1)) begin
              if (!rx_i) begin
                st_q      <= ST_DATA;
                cnt_q     <= '0;
                bitn_q    <= '0;
                sh_q      <= '0;
                par_acc_q <= 1'b0;
                perr_q    <= 1'b0;
              end else begin
                st_q <= ST_IDLE;
              end
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          ST_DATA: begin
            if (at_mid) begin
              cnt_q     <= '0;
              sh_q      <= {rx_i, sh_q[DATA_MAX-1:1]};
              par_acc_q <= par_acc_q ^ rx_i;
              bitn_q    <= bitn_q + 1'b1;
              if (bitn_q == len_eff - 1'b1) st_q <= par_on ? ST_PAR : ST_STOP;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          ST_PAR: begin
            if (at_mid) begin
              cnt_q  <= '0;
              perr_q <= (rx_i != (par_acc_q ^ par_odd));
              st_q   <= ST_STOP;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          ST_STOP: begin
            if (at_mid) begin
              cnt_q         <= '0;
              push_o        <= 1'b1;
              entry_o.data  <= aligned;
              entry_o.perr  <= perr_q;
              entry_o.ferr  <= !rx_i;
              if (!rx_i)           st_q <= ST_HOLD;
              else if (two_stop_i) st_q <= ST_STOP2;
              else                 st_q <= ST_IDLE;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          ST_STOP2: begin
            if (at_mid) begin
              cnt_q <= '0;
              st_q  <= ST_HOLD;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          ST_HOLD: begin
            if (rx_i) st_q <= ST_IDLE;
          end
          default: st_q <= ST_IDLE;
        endcase
      end
    end
  end

  // R9: a disable strobe leaves the frame engine idle on the next cycle
  a_r9_flush_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $past(flush_i) |-> st_q == ST_IDLE);

  // R3: one frame yields at most one character, never two adjacent pushes
  a_r3_single_push: assert property (@(posedge clk) disable iff (!rst_n)
    push_o |=> !push_o);

  // R6: after a framing error the engine waits for the line to return high
  a_r6_hold_after_ferr: assert property (@(posedge clk) disable iff (!rst_n)
    (push_o && entry_o.ferr) |-> st_q == ST_HOLD);

endmodule

// File: rtl/srx_fifo.sv
module srx_fifo
  import srx_pkg::*;
#(
  parameter int DEPTH = 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      push_i,
  input  rx_entry_t din_i,
  input  logic      pop_i,
  output rx_entry_t head_o,
  output logic      valid_o,
  output logic      overflow_o
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  rx_entry_t        mem_q [DEPTH];
  logic [PTR_W-1:0] rd_q, wr_q;
  logic [CNT_W-1:0] cnt_q;
  logic             full;
  logic             do_wr;
  logic             do_rd;

  assign full    = (cnt_q == CNT_W'(DEPTH));
  assign valid_o = (cnt_q != '0);
  assign do_rd   = pop_i && valid_o;
  assign do_wr   = push_i && (!full || do_rd);
  assign head_o  = mem_q[rd_q];

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (do_wr) mem_q[wr_q] <= din_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q       <= '0;
      wr_q       <= '0;
      cnt_q      <= '0;
      overflow_o <= 1'b0;
    end else begin
      overflow_o <= push_i && full && !do_rd;
      if (do_wr) wr_q <= nxt(wr_q);
      if (do_rd) rd_q <= nxt(rd_q);
      case ({do_wr, do_rd})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  // R8: an overflow pulse only follows a drop while the buffer is full
  a_r8_ovf_full: assert property (@(posedge clk) disable iff (!rst_n)
    overflow_o |-> cnt_q == CNT_W'(DEPTH));

  // R7: the head word holds still until it is taken
  a_r7_head_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !pop_i) |=> (valid_o && $stable(head_o)));

  // R7: occupancy never exceeds the buffer depth
  a_r7_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH));

endmodule

// File: rtl/serial_rx_tagged.sv
module serial_rx_tagged
  import srx_pkg::*;
#(
  parameter int DIV_W       = 16,
  parameter int DEPTH       = 2,
  parameter int OSR         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_i,
  input  logic             rx_en_i,
  input  logic             rx_dis_i,
  input  logic [3:0]       char_len_i,
  input  logic [1:0]       parity_sel_i,
  input  logic             two_stop_i,
  input  logic [DIV_W-1:0] div_i,
  output logic [15:0]      rx_word_o,
  output logic             rx_valid_o,
  input  logic             rx_ready_i,
  output logic             overflow_o
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   rx_s;
  logic                   en_q;
  logic                   tick;
  logic                   push;
  rx_entry_t              entry;
  rx_entry_t              head;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '1;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], rx_i};
  end
  assign rx_s = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       en_q <= 1'b0;
    else if (rx_dis_i) en_q <= 1'b0;
    else if (rx_en_i)  en_q <= 1'b1;
  end

  srx_tick #(.DIV_W(DIV_W)) u_tick (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  (en_q),
    .div_i  (div_i),
    .tick_o (tick)
  );

  srx_frame #(.OSR(OSR)) u_frame (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick_i       (tick),
    .rx_i         (rx_s),
    .enabled_i    (en_q),
    .flush_i      (rx_dis_i),
    .char_len_i   (char_len_i),
    .parity_sel_i (parity_sel_i),
    .two_stop_i   (two_stop_i),
    .push_o       (push),
    .entry_o      (entry)
  );

  srx_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk        (clk),
    .rst_n      (rst_n),
    .push_i     (push),
    .din_i      (entry),
    .pop_i      (rx_ready_i),
    .head_o     (head),
    .valid_o    (rx_valid_o),
    .overflow_o (overflow_o)
  );

  assign rx_word_o = pack_word(head);

  // R1: reserved word bits stay zero whenever a word is presented
  a_r1_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_o |-> rx_word_o[13:9] == 5'd0);

  // R9: while disabled no new character can enter the buffer
  a_r9_no_push_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !$past(en_q)) |-> !push);

endmodule

// File: tb/test_serial_rx_tagged.sv
module test_serial_rx_tagged;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx = 1'b1;
  logic        en_s = 1'b0;
  logic        dis_s = 1'b0;
  logic [3:0]  clen = 4'd8;
  logic [1:0]  psel = 2'b00;
  logic        tstop = 1'b0;
  logic [15:0] div = 16'd3;
  logic [15:0] word;
  logic        valid;
  logic        rdy = 1'b0;
  logic        ovf;

  int n_chk = 0;
  int n_bad = 0;
  int ovf_cnt = 0;
  int cyc = 0;
  bit done = 0;

  always #2 clk = ~clk;

  serial_rx_tagged i_serial_rx_tagged (
    .clk(clk), .rst_n(rst_n), .rx_i(rx), .rx_en_i(en_s), .rx_dis_i(dis_s),
    .char_len_i(clen), .parity_sel_i(psel), .two_stop_i(tstop), .div_i(div),
    .rx_word_o(word), .rx_valid_o(valid), .rx_ready_i(rdy), .overflow_o(ovf)
  );

  always @(negedge clk) if (ovf) ovf_cnt++;

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected < 150000", cyc);
      finish_up();
    end
  end

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic int bitc();
    return 16 * (int'(div) + 1);
  endfunction

  task automatic hold_line(input logic v, input int cycles);
    @(negedge clk) rx = v;
    repeat (cycles - 1) @(negedge clk);
  endtask

  task automatic send(input logic [8:0] d, input int len, input logic [1:0] pm,
                      input bit badp, input bit s1, input bit has_s2, input bit s2);
    logic p;
    p = 1'b0;
    hold_line(1'b0, bitc());
    for (int i = 0; i < len; i++) begin
      hold_line(d[i], bitc());
      p ^= d[i];
    end
    if (pm[1]) begin
      if (pm == 2'b11) p = ~p;
      if (badp) p = ~p;
      hold_line(p, bitc());
    end
    hold_line(s1, bitc());
    if (has_s2) hold_line(s2, bitc());
    hold_line(1'b1, 2 * bitc());
  endtask

  task automatic pulse_en();
    @(negedge clk) en_s = 1'b1;
    @(negedge clk) en_s = 1'b0;
  endtask

  task automatic pulse_dis();
    @(negedge clk) dis_s = 1'b1;
    @(negedge clk) dis_s = 1'b0;
  endtask

  task automatic expect_word(input string req, input logic [15:0] exp);
    @(negedge clk);
    chk({req, " valid"}, {15'd0, valid}, 16'd1);
    chk({req, " word"}, word, exp);
    rdy = 1'b1;
    @(negedge clk) rdy = 1'b0;
  endtask

  task automatic expect_empty(input string req);
    @(negedge clk);
    chk({req, " empty"}, {15'd0, valid}, 16'd0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R11 valid at reset", {15'd0, valid}, 16'd0);
    chk("R11 overflow at reset", {15'd0, ovf}, 16'd0);
  endtask

  task automatic t_basic();
    clen = 4'd8; psel = 2'b00; tstop = 1'b0;
    send(9'h0A5, 8, 2'b00, 0, 1, 0, 1);
    expect_word("R1 R10 8N1", 16'h00A5);
    clen = 4'd5;
    send(9'h1F5, 5, 2'b00, 0, 1, 0, 1);
    expect_word("R1 R2 five bits, high bits zero", 16'h0015);
    clen = 4'd9;
    send(9'h1A5, 9, 2'b00, 0, 1, 0, 1);
    expect_word("R2 nine bits", 16'h01A5);
    expect_empty("R7 after pops");
  endtask

  task automatic t_parity();
    clen = 4'd7; psel = 2'b10;
    send(9'h035, 7, 2'b10, 0, 1, 0, 1);
    expect_word("R2 R4 even ok", 16'h0035);
    send(9'h035, 7, 2'b10, 1, 1, 0, 1);
    expect_word("R4 even bad", 16'h4035);
    psel = 2'b11;
    send(9'h06C, 7, 2'b11, 0, 1, 0, 1);
    expect_word("R2 R4 odd ok", 16'h006C);
    send(9'h06C, 7, 2'b11, 1, 1, 0, 1);
    expect_word("R4 odd bad", 16'h406C);
    psel = 2'b00;
  endtask

  task automatic t_frame_err();
    clen = 4'd8; psel = 2'b00; tstop = 1'b0;
    send(9'h03C, 8, 2'b00, 0, 0, 0, 1);
    expect_word("R5 stop low", 16'h803C);
    tstop = 1'b1;
    send(9'h0E7, 8, 2'b00, 0, 1, 1, 0);
    expect_word("R5 second stop unchecked", 16'h00E7);
    expect_empty("R5 no spurious frame");
    tstop = 1'b0;
  endtask

  task automatic t_break();
    hold_line(1'b0, 12 * bitc());
    hold_line(1'b1, 2 * bitc());
    expect_word("R6 break word", 16'h8000);
    expect_empty("R6 single break word");
  endtask

  task automatic t_glitch();
    hold_line(1'b0, 16);
    hold_line(1'b1, 3 * bitc());
    expect_empty("R3 glitch ignored");
    send(9'h081, 8, 2'b00, 0, 1, 0, 1);
    expect_word("R3 frame after glitch", 16'h0081);
  endtask

  task automatic t_overflow();
    int base;
    base = ovf_cnt;
    send(9'h011, 8, 2'b00, 0, 1, 0, 1);
    send(9'h022, 8, 2'b00, 0, 1, 0, 1);
    chk("R8 no overflow at two", 16'(ovf_cnt - base), 16'd0);
    send(9'h033, 8, 2'b00, 0, 1, 0, 1);
    chk("R8 one overflow pulse", 16'(ovf_cnt - base), 16'd1);
    expect_word("R7 R8 oldest kept", 16'h0011);
    expect_word("R7 R8 second kept", 16'h0022);
    expect_empty("R8 third discarded");
  endtask

  task automatic t_disable();
    hold_line(1'b0, bitc());
    hold_line(1'b1, bitc());
    hold_line(1'b0, bitc());
    pulse_dis();
    hold_line(1'b1, 8 * bitc());
    expect_empty("R9 partial flushed");
    send(9'h0F0, 8, 2'b00, 0, 1, 0, 1);
    expect_empty("R9 ignored while disabled");
    @(negedge clk) begin en_s = 1'b1; dis_s = 1'b1; end
    @(negedge clk) begin en_s = 1'b0; dis_s = 1'b0; end
    send(9'h0F0, 8, 2'b00, 0, 1, 0, 1);
    expect_empty("R9 disable wins");
    pulse_en();
    send(9'h05A, 8, 2'b00, 0, 1, 0, 1);
    expect_word("R9 after re-enable", 16'h005A);
  endtask

  task automatic t_divider();
    div = 16'd1;
    hold_line(1'b1, 64);
    send(9'h0C3, 8, 2'b00, 0, 1, 0, 1);
    expect_word("R10 divisor one", 16'h00C3);
    div = 16'd3;
    hold_line(1'b1, 128);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    send(9'h0AA, 8, 2'b00, 0, 1, 0, 1);
    expect_empty("R9 disabled after reset");
    pulse_en();
    hold_line(1'b1, 64);
    t_basic();
    t_parity();
    t_frame_err();
    t_break();
    t_glitch();
    t_overflow();
    t_disable();
    t_divider();
    finish_up();
  end

endmodule